// File: doc/BRIEF.md
# Scalar memory issue and return controller

This block sits between the scalar instruction issue stage and the memory system. On the issue side it looks at the head of the issue queue and sends that request to memory when the request's class still has in-flight budget. Two classes exist: loads, which include every atomic, and stores. Each class may have at most `QSIZE` operations between issue and retirement.

On the return side, memory responses land in one of two internal queues: returned loads (loads and atomics) and returned stores. At most one response retires per cycle. The returned-load head always goes first. A retiring response may need the scalar register file write port. Its retirement also occupies a shared memory-to-register return bus and, unless co-issue return is enabled, the scalar memory unit. Both stay busy for a programmable number of cycles. Retirement lowers the in-flight count of its class and the outstanding-request counters of the wavefront that owns it. Issue raises those same counters.

Top module: `smem_ctrl`

## Requirements
- R1: When the returned-load queue holds any entry, only its head may retire. A store response is considered only while that queue is empty, and a load head that is not ready blocks the stores behind it.
- R2: The selected head retires (`ret_valid`) only if the cycles it has spent at the head of its queue are at least its `rsp_lat`, the return-bus timer is zero, and either `coissue_en` is 1 or the unit timer is zero.
- R3: Kinds are encoded 0 load, 1 store, 2 atomic with return data, 3 atomic without return data. Kinds 0 and 2 also need `srf_can_write` to retire, and they raise `srf_we` in their retirement cycle. Kinds 1 and 3 ignore `srf_can_write` and never raise `srf_we`.
- R4: Kinds 0, 2 and 3 count against `ld_inflight` and use the returned-load queue. Kind 1 counts against `st_inflight` and uses the returned-store queue. Each counter rises by one on issue and falls by one on retirement.
- R5: The issue head is popped (`iss_pop`, mirrored on `mem_req_*`) unless its class in-flight count, after any retirement in the same cycle, equals `QSIZE`.
- R6: Per wavefront, `outst_all` rises on issue and falls on retirement. `outst_rd` does the same for kinds 0, 2 and 3, and `outst_wr` for kinds 1, 2 and 3. Wavefront w uses bits [w*CW +: CW].
- R7: A retirement loads the return-bus timer with `busy_dur`, and loads the unit timer too when `coissue_en` is 0. Each timer then counts down by one per cycle to zero.
- R8: At most one retirement and one issue occur per cycle. A retirement frees budget for an issue of the same class in that same cycle.
- R9: After reset, every counter and timer is zero, both queues are empty, and `ret_valid` and `srf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue queue head present |
| iss_kind | input | 2 | Kind of the issue head |
| iss_wf | input | WW | Wavefront of the issue head |
| iss_pop | output | 1 | Head popped and sent to memory |
| mem_req_valid | output | 1 | Request to memory |
| mem_req_kind | output | 2 | Kind of the request |
| mem_req_wf | output | WW | Wavefront of the request |
| rsp_valid | input | 1 | Memory response arrives |
| rsp_kind | input | 2 | Kind of the response |
| rsp_wf | input | WW | Wavefront of the response |
| rsp_lat | input | LW | Cycles the response must wait at its queue head |
| srf_can_write | input | 1 | Register file can take write operands |
| coissue_en | input | 1 | Co-issue return mode |
| busy_dur | input | TW | Busy interval loaded on retirement |
| ret_valid | output | 1 | A response retires |
| ret_kind | output | 2 | Kind of the retiring response |
| ret_wf | output | WW | Wavefront of the retiring response |
| srf_we | output | 1 | Register file write of load data |
| ld_inflight | output | IW | Load-class in-flight count |
| st_inflight | output | IW | Store-class in-flight count |
| outst_all | output | NWF*CW | Per-wavefront outstanding count |
| outst_rd | output | NWF*CW | Per-wavefront read-outstanding count |
| outst_wr | output | NWF*CW | Per-wavefront write-outstanding count |

## Verification
Retirement and issue can happen in the same cycle. Both touch the same class in-flight counter and, when the wavefronts match, the same outstanding counters. One phase issues densely while returns come back rarely, so the load or store count sits at `QSIZE` exactly when a head of that class retires. The reference model in the bench applies the retirement first and then the issue decision. It compares `iss_pop` in that cycle, and the counters after the edge, against the design.

// File: rtl/smem_ctrl.sv
module smem_ctrl #(
  parameter int NWF   = 4,
  parameter int QSIZE = 4,
  parameter int LW    = 3,
  parameter int TW    = 4,
  parameter int CW    = 4,
  localparam int WW   = (NWF > 1) ? $clog2(NWF) : 1,
  localparam int IW   = $clog2(QSIZE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [1:0]        iss_kind,
  input  logic [WW-1:0]     iss_wf,
  output logic              iss_pop,
  output logic              mem_req_valid,
  output logic [1:0]        mem_req_kind,
  output logic [WW-1:0]     mem_req_wf,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_kind,
  input  logic [WW-1:0]     rsp_wf,
  input  logic [LW-1:0]     rsp_lat,
  input  logic              srf_can_write,
  input  logic              coissue_en,
  input  logic [TW-1:0]     busy_dur,
  output logic              ret_valid,
  output logic [1:0]        ret_kind,
  output logic [WW-1:0]     ret_wf,
  output logic              srf_we,
  output logic [IW-1:0]     ld_inflight,
  output logic [IW-1:0]     st_inflight,
  output logic [NWF*CW-1:0] outst_all,
  output logic [NWF*CW-1:0] outst_rd,
  output logic [NWF*CW-1:0] outst_wr
);
  localparam int AW = (QSIZE > 1) ? $clog2(QSIZE) : 1;
  localparam int EW = 2 + WW + LW;
  localparam logic [1:0] KLD = 2'd0, KST = 2'd1, KAR = 2'd2;

  logic          sel, retire;
  logic [TW-1:0] bus_t, unit_t;

  for (genvar q = 0; q < 2; q++) begin : g_q
    logic [EW-1:0] mem [QSIZE];
    logic [AW-1:0] rp, wp;
    logic [IW-1:0] cnt;
    logic [LW-1:0] age;
    logic          push, pop;

    assign push = rsp_valid && ((rsp_kind == KST) == (q == 1));
    assign pop  = retire && (sel == (q == 1));

    always_ff @(posedge clk)
      if (push) mem[wp] <= {rsp_kind, rsp_wf, rsp_lat};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rp <= '0; wp <= '0; cnt <= '0; age <= '0;
      end else begin
        if (push) wp <= (wp == AW'(QSIZE - 1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == AW'(QSIZE - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + IW'(push) - IW'(pop);
        if (pop) age <= '0;
        else if (cnt != 0 && age != {LW{1'b1}}) age <= age + 1'b1;
      end
    end
  end

  logic [EW-1:0] hd;
  logic [LW-1:0] hd_age, hd_lat;
  logic [1:0]    hd_kind;
  logic [WW-1:0] hd_wf;
  logic          have, needs_srf;

  assign sel       = (g_q[0].cnt == 0);
  assign hd        = sel ? g_q[1].mem[g_q[1].rp] : g_q[0].mem[g_q[0].rp];
  assign hd_age    = sel ? g_q[1].age : g_q[0].age;
  assign hd_kind   = hd[EW-1 -: 2];
  assign hd_wf     = hd[LW +: WW];
  assign hd_lat    = hd[LW-1:0];
  assign have      = (g_q[0].cnt != 0) || (g_q[1].cnt != 0);
  assign needs_srf = (hd_kind == KLD) || (hd_kind == KAR);

  assign retire = have && (hd_age >= hd_lat) && (bus_t == 0) &&
                  (!needs_srf || srf_can_write) && (coissue_en || unit_t == 0);

  assign ret_valid = retire;
  assign ret_kind  = hd_kind;
  assign ret_wf    = hd_wf;
  assign srf_we    = retire && needs_srf;

  logic          ret_ld, ret_st, iss_ld, pop_ld, pop_st;
  logic [IW-1:0] ld_eff, st_eff;

  assign ret_ld = retire && !sel;
  assign ret_st = retire && sel;
  assign ld_eff = ld_inflight - IW'(ret_ld);
  assign st_eff = st_inflight - IW'(ret_st);
  assign iss_ld = (iss_kind != KST);
  assign iss_pop = iss_valid && (iss_ld ? (ld_eff < IW'(QSIZE)) : (st_eff < IW'(QSIZE)));
  assign pop_ld = iss_pop && iss_ld;
  assign pop_st = iss_pop && !iss_ld;

  assign mem_req_valid = iss_pop;
  assign mem_req_kind  = iss_kind;
  assign mem_req_wf    = iss_wf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_inflight <= '0; st_inflight <= '0; bus_t <= '0; unit_t <= '0;
    end else begin
      ld_inflight <= ld_inflight + IW'(pop_ld) - IW'(ret_ld);
      st_inflight <= st_inflight + IW'(pop_st) - IW'(ret_st);
      if (retire) bus_t <= busy_dur;
      else if (bus_t != 0) bus_t <= bus_t - 1'b1;
      if (retire && !coissue_en) unit_t <= busy_dur;
      else if (unit_t != 0) unit_t <= unit_t - 1'b1;
    end
  end

  for (genvar w = 0; w < NWF; w++) begin : g_wf
    logic [CW-1:0] c_all, c_rd, c_wr;
    logic inc, dec;
    assign inc = iss_pop && (iss_wf == WW'(w));
    assign dec = retire && (hd_wf == WW'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c_all <= '0; c_rd <= '0; c_wr <= '0;
      end else begin
        c_all <= c_all + CW'(inc) - CW'(dec);
        c_rd  <= c_rd + CW'(inc && iss_kind != KST) - CW'(dec && hd_kind != KST);
        c_wr  <= c_wr + CW'(inc && iss_kind != KLD) - CW'(dec && hd_kind != KLD);
      end
    end

    assign outst_all[w*CW +: CW] = c_all;
    assign outst_rd[w*CW +: CW]  = c_rd;
    assign outst_wr[w*CW +: CW]  = c_wr;
  end
endmodule

// File: rtl/smem_ctrl_chk.sv
module smem_ctrl_chk #(
  parameter int QSIZE = 4,
  parameter int TW    = 4,
  parameter int IW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic [1:0]    iss_kind,
  input logic          iss_pop,
  input logic          ret_valid,
  input logic [1:0]    ret_kind,
  input logic          srf_we,
  input logic          srf_can_write,
  input logic          coissue_en,
  input logic [TW-1:0] busy_dur,
  input logic [IW-1:0] ld_inflight,
  input logic [IW-1:0] st_inflight
);
  a_r4_ld_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind != 2'd1) |-> (ld_inflight != 0));
  a_r4_st_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind == 2'd1) |-> (st_inflight != 0));
  a_r5_ld_budget: assert property (@(posedge clk) disable iff (!rst_n)
    ld_inflight <= IW'(QSIZE));
  a_r5_st_budget: assert property (@(posedge clk) disable iff (!rst_n)
    st_inflight <= IW'(QSIZE));
  a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_kind == 2'd1 && st_inflight == IW'(QSIZE) &&
     !(ret_valid && ret_kind == 2'd1)) |-> !iss_pop);
  a_r3_srf_gate: assert property (@(posedge clk) disable iff (!rst_n)
    srf_we |-> (srf_can_write && ret_valid));
  a_r3_no_srf_store: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind[0]) |-> !srf_we);
  a_r7_bus_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && busy_dur != 0) |=> !ret_valid);
  a_r7_unit_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && busy_dur != 0 && !coissue_en) |=> !ret_valid);
endmodule

bind smem_ctrl smem_ctrl_chk #(.QSIZE(QSIZE), .TW(TW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
  .iss_pop(iss_pop), .ret_valid(ret_valid), .ret_kind(ret_kind),
  .srf_we(srf_we), .srf_can_write(srf_can_write), .coissue_en(coissue_en),
  .busy_dur(busy_dur), .ld_inflight(ld_inflight), .st_inflight(st_inflight)
);

// File: tb/smem_ctrl_tb_top.sv
module smem_ctrl_tb_top;
  localparam int NWF = 4, QSIZE = 4, LW = 3, TW = 4, CW = 4, WW = 2, IW = 3;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, rsp_valid = 0, srf_can_write = 0, coissue_en = 0;
  logic [1:0] iss_kind = 0, rsp_kind = 0;
  logic [WW-1:0] iss_wf = 0, rsp_wf = 0;
  logic [LW-1:0] rsp_lat = 0;
  logic [TW-1:0] busy_dur = 0;
  logic iss_pop, mem_req_valid, ret_valid, srf_we;
  logic [1:0] mem_req_kind, ret_kind;
  logic [WW-1:0] mem_req_wf, ret_wf;
  logic [IW-1:0] ld_inflight, st_inflight;
  logic [NWF*CW-1:0] outst_all, outst_rd, outst_wr;

  smem_ctrl dut_i (.*);

  always #10 clk = ~clk;

  typedef struct packed { logic [1:0] k; logic [1:0] wf; logic [2:0] lat; } ent_t;
  ent_t mq0[$], mq1[$], pend[$];
  int a0, a1, bus_t, unit_t, ld_inf, st_inf;
  int oc[NWF], rc[NWF], wc[NWF];
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic bit class_ld(logic [1:0] k);
    return k != 2'd1;
  endfunction

  function automatic bit needs_srf(logic [1:0] k);
    return k == 2'd0 || k == 2'd2;
  endfunction

  task automatic step(int ip, int rp, int sp, int cmode, int dmax);
    bit sel, mv, eret, epop, srf_ok;
    ent_t m, r;
    int age, s0, s1;
    @(negedge clk);
    iss_valid = ($urandom % 100) < ip;
    iss_kind = 2'($urandom); iss_wf = 2'($urandom);
    rsp_valid = 0;
    if (pend.size() > 0 && ($urandom % 100) < rp) begin
      int idx = $urandom % pend.size();
      r = pend[idx]; pend.delete(idx);
      r.lat = 3'($urandom);
      rsp_valid = 1; rsp_kind = r.k; rsp_wf = r.wf; rsp_lat = r.lat;
    end
    srf_can_write = ($urandom % 100) < sp;
    coissue_en = (cmode == 2) ? 1'($urandom) : cmode[0];
    busy_dur = TW'($urandom % (dmax + 1));
    #2;
    chk("R4 ld_inflight", ld_inflight, ld_inf);
    chk("R4 st_inflight", st_inflight, st_inf);
    for (int w = 0; w < NWF; w++) begin
      chk("R6 outst_all", outst_all[w*CW +: CW], oc[w]);
      chk("R6 outst_rd", outst_rd[w*CW +: CW], rc[w]);
      chk("R6 outst_wr", outst_wr[w*CW +: CW], wc[w]);
    end
    sel = (mq0.size() == 0);
    mv = (mq0.size() + mq1.size()) > 0;
    m = sel ? (mq1.size() > 0 ? mq1[0] : '0) : mq0[0];
    age = sel ? a1 : a0;
    srf_ok = !needs_srf(m.k) || srf_can_write;
    eret = mv && age >= m.lat && bus_t == 0 && srf_ok && (coissue_en || unit_t == 0);
    epop = iss_valid && (class_ld(iss_kind) ? (ld_inf - (eret && !sel)) < QSIZE
                                            : (st_inf - (eret && sel)) < QSIZE);
    chk("R2,R7 ret_valid", ret_valid, eret);
    if (eret) begin
      chk("R1 ret_kind", ret_kind, m.k);
      chk("R1 ret_wf", ret_wf, m.wf);
    end
    chk("R3 srf_we", srf_we, eret && needs_srf(m.k));
    chk("R5,R8 iss_pop", iss_pop, epop);
    chk("R5 mem_req_valid", mem_req_valid, epop);
    s0 = mq0.size(); s1 = mq1.size();
    if (eret) begin
      if (sel) begin void'(mq1.pop_front()); st_inf--; end
      else begin void'(mq0.pop_front()); ld_inf--; end
      oc[m.wf]--;
      if (m.k != 2'd1) rc[m.wf]--;
      if (m.k != 2'd0) wc[m.wf]--;
    end
    if (eret) bus_t = busy_dur; else if (bus_t > 0) bus_t--;
    if (eret && !coissue_en) unit_t = busy_dur; else if (unit_t > 0) unit_t--;
    if (eret && !sel) a0 = 0; else if (s0 > 0 && a0 < 7) a0++;
    if (eret && sel) a1 = 0; else if (s1 > 0 && a1 < 7) a1++;
    if (rsp_valid) begin
      if (class_ld(r.k)) mq0.push_back(r); else mq1.push_back(r);
    end
    if (epop) begin
      ent_t n;
      n.k = iss_kind; n.wf = iss_wf; n.lat = 0;
      pend.push_back(n);
      if (class_ld(iss_kind)) ld_inf++; else st_inf++;
      oc[iss_wf]++;
      if (iss_kind != 2'd1) rc[iss_wf]++;
      if (iss_kind != 2'd0) wc[iss_wf]++;
    end
  endtask

  initial begin
    void'($urandom(32'h5ca1a));
    a0 = 0; a1 = 0; bus_t = 0; unit_t = 0; ld_inf = 0; st_inf = 0;
    for (int w = 0; w < NWF; w++) begin oc[w] = 0; rc[w] = 0; wc[w] = 0; end
    repeat (3) @(negedge clk);
    #2;
    chk("R9 ret_valid", ret_valid, 0);
    chk("R9 srf_we", srf_we, 0);
    chk("R9 ld_inflight", ld_inflight, 0);
    chk("R9 st_inflight", st_inflight, 0);
    chk("R9 outst_all", int'(outst_all), 0);
    chk("R9 outst_rd", int'(outst_rd), 0);
    chk("R9 outst_wr", int'(outst_wr), 0);
    @(negedge clk); rst_n = 1;
    repeat (2000) step(80, 70, 100, 1, 0);
    repeat (2000) step(60, 60, 90, 0, 5);
    repeat (2000) step(70, 50, 30, 2, 3);
    repeat (3000) step(95, 10, 80, 2, 1);
    repeat (1000) step(0, 40, 100, 0, 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule